// File: doc/BRIEF.md
# Duplex Output Guard with Triplex Escalation

The block supervises two redundant copies of a functional unit. A launch pulse starts a programmable settle timer, so the units have time to produce their outputs. When the timer runs out and the needed valid strobes are high, the block compares the outputs and folds them into a short checksum. That checksum is checked against a reference value supplied with the operation. The reference check lets the guard catch faults in its own result path as well as faults in the units.

Any duplex disagreement, in data or in checksum, moves the guard into triplex mode, and a cold-standby third unit joins the vote. In triplex mode a majority vote names the dissenting unit. The guard blames itself in two cases: when no majority exists, or when the majority's checksum does not match the reference. A blamed unit or a self-fault raises a recovery request, which stays high until it is acknowledged. The acknowledge returns the guard to duplex mode, so one fault episode costs two mode changes. While the guard is in triplex mode it counts good and bad verdicts separately, and these counts can be used for availability measurement. The structure is the same for any kind of monitored unit, and the data width is a parameter.

Top module: `dx_guard`

## Requirements
- R1: After a synchronous reset the mode is duplex (mode_tmr=0), both flags and rec_req are 0, fault_id is 2'b00 and both counters are 0.
- R2: A launch accepted while the guard is idle produces its verdict on the (settle_cycles+1)-th rising edge after the accepting edge. No output changes before that edge, and a launch that arrives during the settle period is ignored.
- R3: The verdict waits, after the settle time, until a_vld and b_vld are high (and c_vld as well in triplex mode).
- R4: In duplex mode, a bitwise difference between unit_a and unit_b sets disc_flag, switches to triplex mode and clears both counters.
- R5: The checksum is the XOR of the CKW-bit slices of the value under test. In duplex mode, agreeing outputs whose checksum differs from ref_sum switch to triplex mode and clear both counters, and leave disc_flag unchanged.
- R6: In triplex mode, when exactly one unit dissents and the majority checksum matches ref_sum, rec_req rises and fault_id names the dissenter (01=A, 10=B, 11=C). The guard stays in triplex mode and bad_cnt increments.
- R7: In triplex mode, three mutually different outputs, or a majority whose checksum mismatches ref_sum, set self_flag, raise rec_req, give fault_id 00 and increment bad_cnt.
- R8: In triplex mode, three agreeing outputs with a matching checksum increment good_cnt. They return the guard to duplex mode only if no request is pending. A clean duplex verdict changes nothing.
- R9: rec_req stays high until ack is sampled high, and that ack clears rec_req and selects duplex mode. An ack with no pending request has no effect.
- R10: disc_flag and self_flag stay set until reset.
- R11: good_cnt and bad_cnt saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| settle_cycles | input | SCW | Propagation allowance in cycles |
| launch | input | 1 | Start of an operation on the units |
| unit_a | input | W | Output of unit A |
| a_vld | input | 1 | Unit A output valid |
| unit_b | input | W | Output of unit B |
| b_vld | input | 1 | Unit B output valid |
| unit_c | input | W | Output of standby unit C |
| c_vld | input | 1 | Unit C output valid |
| ref_sum | input | CKW | Stored reference checksum for the operation |
| ack | input | 1 | Acknowledge of the recovery request |
| mode_tmr | output | 1 | 0 duplex, 1 triplex |
| disc_flag | output | 1 | Sticky duplex data discrepancy |
| self_flag | output | 1 | Sticky guard self-fault |
| rec_req | output | 1 | Recovery request |
| fault_id | output | 2 | Blamed unit, 00 for the guard itself |
| good_cnt | output | ECW | Good verdicts in the current repair period |
| bad_cnt | output | ECW | Bad verdicts in the current repair period |

## Verification
The bench builds the guard with W=16, CKW=4, SCW=4 and ECW=3. With a 3-bit counter, saturation is reached after seven faulty triplex verdicts, all inside one repair period. Settle values of 0 and 3 cover both the immediate verdict and an extended wait, and the longer wait leaves room to inject an ignored second launch. The reference checksum is computed from four 4-bit slices, which makes checksum mismatches on agreeing data easy to build.

// File: rtl/dxg_pkg.sv
package dxg_pkg;

    typedef enum logic {
        MODE_DUPLEX  = 1'b0,
        MODE_TRIPLEX = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        UID_NONE = 2'b00,
        UID_A    = 2'b01,
        UID_B    = 2'b10,
        UID_C    = 2'b11
    } unit_id_e;

    typedef enum logic [2:0] {
        VD_CLEAN,
        VD_ESC_DATA,
        VD_ESC_SUM,
        VD_UNIT,
        VD_SELF
    } verdict_e;

    typedef struct packed {
        verdict_e kind;
        unit_id_e culprit;
    } verdict_t;

endpackage

// File: rtl/dxg_settle_timer.sv
module dxg_settle_timer #(
    parameter int SCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           launch,
    input  logic [SCW-1:0] settle_cycles,
    input  logic           go_ok,
    output logic           busy,
    output logic           fire
);
    logic [SCW-1:0] remaining;

    assign fire = busy && (remaining == '0) && go_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            remaining <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy      <= 1'b1;
                remaining <= settle_cycles;
            end
        end else if (remaining != '0) begin
            remaining <= remaining - 1'b1;
        end else if (go_ok) begin
            busy <= 1'b0;
        end
    end

    // R2: an idle launch loads the full allowance
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && launch) |=> (busy && remaining == $past(settle_cycles)));

    // R2: the allowance counts down one per cycle and cannot end early
    p_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && remaining != '0) |=> (busy && remaining == SCW'($past(remaining) - 1'b1)));

endmodule

// File: rtl/dxg_vote_eval.sv
module dxg_vote_eval
    import dxg_pkg::*;
#(
    parameter int W   = 16,
    parameter int CKW = 4
) (
    input  mode_e          mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    input  logic [CKW-1:0] ref_sum,
    output verdict_t       verdict
);
    localparam int NSL = W / CKW;

    logic           ab, ac, bc;
    logic [W-1:0]   maj;
    logic [CKW-1:0] sum;
    logic           sum_ok;

    assign ab  = (a == b);
    assign ac  = (a == c);
    assign bc  = (b == c);
    assign maj = (mode == MODE_TRIPLEX && !ab && !ac) ? b : a;

    always_comb begin
        sum = '0;
        for (int i = 0; i < NSL; i++) sum = sum ^ maj[i*CKW +: CKW];
    end
    assign sum_ok = (sum == ref_sum);

    always_comb begin
        verdict.kind    = VD_CLEAN;
        verdict.culprit = UID_NONE;
        if (mode == MODE_DUPLEX) begin
            if (!ab)         verdict.kind = VD_ESC_DATA;
            else if (!sum_ok) verdict.kind = VD_ESC_SUM;
        end else if (ab && ac) begin
            verdict.kind = sum_ok ? VD_CLEAN : VD_SELF;
        end else if (!ab && !ac && !bc) begin
            verdict.kind = VD_SELF;
        end else if (!sum_ok) begin
            verdict.kind = VD_SELF;
        end else begin
            verdict.kind = VD_UNIT;
            if (ab)      verdict.culprit = UID_C;
            else if (ac) verdict.culprit = UID_B;
            else         verdict.culprit = UID_A;
        end
    end

endmodule

// File: rtl/dx_guard.sv
module dx_guard
    import dxg_pkg::*;
#(
    parameter int W   = 16,
    parameter int CKW = 4,
    parameter int SCW = 4,
    parameter int ECW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [SCW-1:0] settle_cycles,
    input  logic           launch,
    input  logic [W-1:0]   unit_a,
    input  logic           a_vld,
    input  logic [W-1:0]   unit_b,
    input  logic           b_vld,
    input  logic [W-1:0]   unit_c,
    input  logic           c_vld,
    input  logic [CKW-1:0] ref_sum,
    input  logic           ack,
    output logic           mode_tmr,
    output logic           disc_flag,
    output logic           self_flag,
    output logic           rec_req,
    output logic [1:0]     fault_id,
    output logic [ECW-1:0] good_cnt,
    output logic [ECW-1:0] bad_cnt
);
    localparam logic [ECW-1:0] CNT_MAX = {ECW{1'b1}};

    mode_e    mode;
    unit_id_e id_q;
    verdict_t vd;
    logic     go_ok, fire, busy, clr_cnt;

    assign go_ok    = a_vld && b_vld && (mode == MODE_DUPLEX || c_vld);
    assign clr_cnt  = fire && (vd.kind == VD_ESC_DATA || vd.kind == VD_ESC_SUM);
    assign mode_tmr = (mode == MODE_TRIPLEX);
    assign fault_id = id_q;

    dxg_settle_timer #(.SCW(SCW)) u_timer (
        .clk(clk), .rst(rst), .launch(launch), .settle_cycles(settle_cycles),
        .go_ok(go_ok), .busy(busy), .fire(fire)
    );

    dxg_vote_eval #(.W(W), .CKW(CKW)) u_eval (
        .mode(mode), .a(unit_a), .b(unit_b), .c(unit_c),
        .ref_sum(ref_sum), .verdict(vd)
    );

    function automatic logic [ECW-1:0] sat_inc(input logic [ECW-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_DUPLEX;
            id_q      <= UID_NONE;
            disc_flag <= 1'b0;
            self_flag <= 1'b0;
            rec_req   <= 1'b0;
            good_cnt  <= '0;
            bad_cnt   <= '0;
        end else begin
            if (fire) begin
                unique case (vd.kind)
                    VD_ESC_DATA: begin
                        disc_flag <= 1'b1;
                        mode      <= MODE_TRIPLEX;
                        good_cnt  <= '0;
                        bad_cnt   <= '0;
                    end
                    VD_ESC_SUM: begin
                        mode     <= MODE_TRIPLEX;
                        good_cnt <= '0;
                        bad_cnt  <= '0;
                    end
                    VD_UNIT: begin
                        rec_req <= 1'b1;
                        id_q    <= vd.culprit;
                        bad_cnt <= sat_inc(bad_cnt);
                    end
                    VD_SELF: begin
                        self_flag <= 1'b1;
                        rec_req   <= 1'b1;
                        id_q      <= UID_NONE;
                        bad_cnt   <= sat_inc(bad_cnt);
                    end
                    default: begin
                        if (mode == MODE_TRIPLEX) begin
                            good_cnt <= sat_inc(good_cnt);
                            if (!rec_req) mode <= MODE_DUPLEX;
                        end
                    end
                endcase
            end
            if (ack && rec_req) begin
                rec_req <= 1'b0;
                mode    <= MODE_DUPLEX;
            end
        end
    end

    // R9: request holds without acknowledge
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rec_req && !ack) |=> rec_req);

    // R9: acknowledge releases the request and restores duplex mode
    p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rec_req && ack) |=> (!rec_req && !mode_tmr));

    // R6: a pending request only exists in triplex mode
    p_req_triplex_r6: assert property (@(posedge clk) disable iff (rst)
        rec_req |-> mode_tmr);

    // R10: flags are sticky
    p_disc_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        disc_flag |=> disc_flag);
    p_self_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        self_flag |=> self_flag);

    // R11: saturated bad counter stays put unless a new episode clears it
    p_bad_sat_r11: assert property (@(posedge clk) disable iff (rst)
        (bad_cnt == CNT_MAX && !clr_cnt) |=> (bad_cnt == CNT_MAX));

endmodule

// File: tb/sim_dx_guard.sv
module sim_dx_guard;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16, CKW = 4, SCW = 4, ECW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SCW-1:0] settle_cycles = '0;
    logic launch = 1'b0, a_vld = 1'b0, b_vld = 1'b0, c_vld = 1'b0, ack = 1'b0;
    logic [W-1:0] unit_a = '0, unit_b = '0, unit_c = '0;
    logic [CKW-1:0] ref_sum = '0;
    logic mode_tmr, disc_flag, self_flag, rec_req;
    logic [1:0] fault_id;
    logic [ECW-1:0] good_cnt, bad_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dx_guard #(.W(W), .CKW(CKW), .SCW(SCW), .ECW(ECW)) u0 (
        .clk(clk), .rst(rst), .settle_cycles(settle_cycles), .launch(launch),
        .unit_a(unit_a), .a_vld(a_vld), .unit_b(unit_b), .b_vld(b_vld),
        .unit_c(unit_c), .c_vld(c_vld), .ref_sum(ref_sum), .ack(ack),
        .mode_tmr(mode_tmr), .disc_flag(disc_flag), .self_flag(self_flag),
        .rec_req(rec_req), .fault_id(fault_id), .good_cnt(good_cnt), .bad_cnt(bad_cnt)
    );

    typedef struct {
        string tag;
        logic mode, disc, slf, req;
        logic [1:0] id;
        logic [ECW-1:0] good, bad;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic m_mode = 0, m_disc = 0, m_self = 0, m_req = 0;
    logic [1:0] m_id = 0;
    logic [ECW-1:0] m_good = 0, m_bad = 0;

    function automatic logic [CKW-1:0] bfold(input logic [W-1:0] x);
        return x[3:0] ^ x[7:4] ^ x[11:8] ^ x[15:12];
    endfunction

    function automatic logic [ECW-1:0] binc(input logic [ECW-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag; e.mode = m_mode; e.disc = m_disc; e.slf = m_self; e.req = m_req;
        e.id = m_id; e.good = m_good; e.bad = m_bad;
        q.push_back(e);
        -> chk_ev;
    endtask

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(mode_tmr == e.mode,   {e.tag, " mode"}, mode_tmr, e.mode);
                chk(disc_flag == e.disc,  {e.tag, " disc"}, disc_flag, e.disc);
                chk(self_flag == e.slf,   {e.tag, " self"}, self_flag, e.slf);
                chk(rec_req == e.req,     {e.tag, " req"},  rec_req, e.req);
                chk(fault_id == e.id,     {e.tag, " id"},   fault_id, e.id);
                chk(good_cnt == e.good,   {e.tag, " good"}, good_cnt, e.good);
                chk(bad_cnt == e.bad,     {e.tag, " bad"},  bad_cnt, e.bad);
            end
        end
    end

    task automatic model_self();
        m_self = 1; m_req = 1; m_id = 2'b00; m_bad = binc(m_bad);
    endtask

    task automatic model(input logic [W-1:0] a, b, c, input logic [CKW-1:0] r);
        logic [W-1:0] mj;
        logic [1:0] cul;
        if (!m_mode) begin
            if (a != b) begin m_disc = 1; m_mode = 1; m_good = 0; m_bad = 0; end
            else if (bfold(a) != r) begin m_mode = 1; m_good = 0; m_bad = 0; end
        end else if (a == b && b == c) begin
            if (bfold(a) == r) begin m_good = binc(m_good); if (!m_req) m_mode = 0; end
            else model_self();
        end else begin
            if (a == b)      begin cul = 2'b11; mj = a; end
            else if (a == c) begin cul = 2'b10; mj = a; end
            else if (b == c) begin cul = 2'b01; mj = b; end
            else             begin cul = 2'b00; mj = a; end
            if (cul == 2'b00 || bfold(mj) != r) model_self();
            else begin m_req = 1; m_id = cul; m_bad = binc(m_bad); end
        end
    endtask

    task automatic op(input logic [W-1:0] a, b, c, input logic [CKW-1:0] r,
                      input int s, input int hold, input bit relaunch, input string tag);
        logic [ECW-1:0] pre_bad;
        logic pre_mode;
        pre_bad = bad_cnt; pre_mode = mode_tmr;
        @(negedge clk);
        unit_a = a; unit_b = b; unit_c = c; ref_sum = r; settle_cycles = SCW'(s);
        a_vld = 1; c_vld = 1; b_vld = (hold == 0); launch = 1;
        @(negedge clk);
        launch = 0;
        for (int i = 0; i < s + hold; i++) begin
            @(negedge clk);
            launch = (relaunch && i == 0);
        end
        launch = 0;
        // R2/R3: nothing may have changed before the verdict edge
        chk(mode_tmr == pre_mode, {tag, " R2 R3 no early verdict mode"}, mode_tmr, pre_mode);
        chk(bad_cnt == pre_bad, {tag, " R2 R3 no early verdict bad"}, bad_cnt, pre_bad);
        b_vld = 1;
        @(negedge clk);
        model(a, b, c, r);
        push(tag);
        if (relaunch) begin
            repeat (s + 3) @(negedge clk);
            chk(bad_cnt == m_bad, "R2 ignored relaunch", bad_cnt, m_bad);
        end
    endtask

    task automatic do_ack(input string tag);
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        if (m_req) begin m_req = 0; m_mode = 0; end
        push(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_mode = 0; m_disc = 0; m_self = 0; m_req = 0; m_id = 0; m_good = 0; m_bad = 0;
        push(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] g;
        g = 16'h1234;                       // checksum 4'h4
        repeat (2) @(negedge clk);
        do_reset("R1 reset state");
        op(g, g, g, 4'h4, 3, 0, 0, "R8 duplex clean");
        op(g, 16'h1235, g, 4'h4, 0, 0, 0, "R4 duplex data mismatch");
        op(g, g, 16'h0F0F, 4'h4, 3, 0, 1, "R6 dissent C");
        do_ack("R9 ack returns duplex");
        do_ack("R9 ack without request");
        op(g, g, g, 4'h5, 1, 0, 0, "R5 checksum escalation R10 disc kept");
        op(16'h0001, g, g, 4'h4, 2, 4, 0, "R3 wait for strobe R6 dissent A");
        op(g, 16'hAAAA, g, 4'h4, 0, 0, 0, "R6 dissent B");
        op(g, g, g, 4'h4, 0, 0, 0, "R8 clean with pending request");
        for (int i = 0; i < 8; i++) op(g, g, 16'h0000, 4'h4, 0, 0, 0, "R11 saturation");
        do_ack("R9 ack after saturation");
        do_reset("R10 flags cleared by reset");
        op(g, 16'h1111, g, 4'h4, 0, 0, 0, "R4 second episode");
        op(g, 16'h1111, 16'h2222, 4'h4, 1, 0, 0, "R7 no majority");
        do_ack("R9 ack self fault");
        op(g, 16'h1111, g, 4'h4, 0, 0, 0, "R4 third episode");
        op(g, g, 16'h0000, 4'h7, 0, 0, 0, "R7 majority checksum bad");
        do_ack("R9 ack");
        op(g, g, g, 4'h9, 0, 0, 0, "R5 checksum escalation");
        op(g, g, g, 4'h4, 2, 0, 0, "R8 clean triplex returns duplex");
        @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule